// File: doc/BRIEF.md
# DS1 Framed Test Pattern Generator

This block produces a serial DS1 test bit stream, one bit per clock, for loopback and bit-error testing. A 3-bit selector picks the payload source: one of three pseudo-random sequences, a quasi-random signal with a cap on zero runs, an alternating pattern, a constant-ones pattern or a repeating 32-bit user word. The payload goes out as is, or it is wrapped in 193-bit DS1 frames that use either 12-frame superframe or 24-frame extended superframe framing.

Two test options sit on top of the stream. A transmit-invert control flips every outgoing bit. A framing-error control inverts the framing bit of the twelfth frame of every superframe, which lets a far-end monitor see framing errors on purpose. The launch edge of the output can be the rising or the falling edge of the clock.

The configuration inputs are registered inside the block. While reset is high that register holds its reset values: everything zero except the launch edge, which is rising. The stream restarts from its first bit after each reset.

Top module: `ds1_tpat_gen`

## Requirements
- R1: While `rst` is high, `tx_valid` and `tx_data` are 0. After `rst` falls, `tx_valid` stays 0 for the first rising edge and rises on the second rising edge. It then stays high and one bit is launched per clock.
- R2: Selector 000 gives the x^15+x^14+1 sequence, 001 gives x^20+x^3+1 and 011 gives x^23+x^18+1. Each is a shift register seeded with all ones. For taps N and K, each payload bit is b = s[N-1] xor s[K-1], then the register shifts left with b entering at bit 0.
- R3: Selector 010 runs the x^20+x^17+1 register in the same way. When a raw 0 would become the 14th consecutive zero at the output, a 1 is sent in its place. The register still shifts in the raw bit.
- R4: Selector 100 alternates 0,1,0,1,… starting with 0. Selectors 101 and 110 both send constant ones.
- R5: Selector 111 sends the 32-bit user word from bit 31 down to bit 0, then repeats.
- R6: When transmit-invert is set, every output bit is inverted, framing bits included.
- R7: When framed mode is clear, every bit is a payload bit and no framing bits are inserted.
- R8: When framed mode is set, each frame is 193 bits: a framing bit first, then 192 payload bits. The payload source does not advance during the framing bit.
- R9: With superframe framing (extended mode clear), frames 1 to 12 carry the framing bits 1,0,0,0,1,1,0,1,1,1,0,0 in that order, repeating.
- R10: With extended superframe framing, frames 4, 8, 12, 16, 20 and 24 of the 24-frame superframe carry 0,0,1,0,1,1 in that order. Every other frame carries a framing bit of 1.
- R11: When the framing-error control is set, the framing bit of frame 12 is inverted. In superframe mode this applies to every 12-frame group. In extended mode it applies to frame 12 of each 24-frame superframe.
- R12: With rising launch selected, `tx_data` changes just after the rising edge. With falling launch selected, the same bit sequence changes just after the falling edge instead, half a clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pattern | input | 3 | Payload selector |
| cfg_tx_invert | input | 1 | Invert all output bits |
| cfg_framed | input | 1 | Insert DS1 framing bits |
| cfg_esf | input | 1 | 1 = extended superframe, 0 = superframe |
| cfg_frame_err | input | 1 | Invert the framing bit of frame 12 |
| cfg_rise_edge | input | 1 | 1 = launch on rising edge, 0 = falling edge |
| cfg_user_word | input | 32 | Repeating user pattern word |
| tx_data | output | 1 | Serial test data |
| tx_valid | output | 1 | High while `tx_data` carries stream bits |

## Verification
The assertions assume the configuration inputs change only while `rst` is high. The pattern state is not reseeded when the configuration changes mid-stream. They also assume `rst` changes well away from the falling edge, because the falling-edge output register samples it there. The bench therefore applies every configuration, directed or drawn at random, together with a reset pulse, and holds it constant for the whole run. All input changes happen one nanosecond after a rising edge.

// File: rtl/ds1tp_pkg.sv
package ds1tp_pkg;

    localparam int LFSR_W = 23;

    typedef enum logic [2:0] {
        PAT_PRBS15 = 3'b000,
        PAT_PRBS20 = 3'b001,
        PAT_QRSS   = 3'b010,
        PAT_PRBS23 = 3'b011,
        PAT_ALT    = 3'b100,
        PAT_ONES   = 3'b101,
        PAT_SPARE  = 3'b110,
        PAT_USER   = 3'b111
    } pat_e;

    typedef struct packed {
        pat_e sel;
        logic tx_inv;
        logic framed;
        logic esf;
        logic finv;
        logic rise;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel: PAT_PRBS15, tx_inv: 1'b0, framed: 1'b0,
                                   esf: 1'b0, finv: 1'b0, rise: 1'b1};

    // bit i = framing bit of superframe frame i+1
    localparam logic [11:0] SF_PATTERN  = 12'b0011_1011_0001;
    // bit i = framing bit of extended frame 4*(i+1)
    localparam logic [5:0]  ESF_PATTERN = 6'b11_0100;

    function automatic logic lfsr_feedback(logic [LFSR_W-1:0] s, pat_e sel);
        case (sel)
            PAT_PRBS15: return s[14] ^ s[13];
            PAT_PRBS20: return s[19] ^ s[2];
            PAT_QRSS:   return s[19] ^ s[16];
            PAT_PRBS23: return s[22] ^ s[17];
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic uses_lfsr(pat_e sel);
        return (sel == PAT_PRBS15) || (sel == PAT_PRBS20) ||
               (sel == PAT_QRSS)   || (sel == PAT_PRBS23);
    endfunction

endpackage

// File: rtl/ds1tp_payload.sv
module ds1tp_payload
    import ds1tp_pkg::*;
#(
    parameter int USER_W         = 32,
    parameter int QRSS_MAX_ZEROS = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  pat_e              sel,
    input  logic [USER_W-1:0] user_word,
    input  logic              adv,
    output logic              pay_bit
);
    localparam int UIDX_W = $clog2(USER_W);
    localparam int ZC_W   = $clog2(QRSS_MAX_ZEROS + 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [ZC_W-1:0]   zrun_q;
    logic              alt_q;
    logic [UIDX_W-1:0] uidx_q;
    logic              fb;

    always_comb begin
        fb = lfsr_feedback(lfsr_q, sel);
        case (sel)
            PAT_PRBS15, PAT_PRBS20, PAT_PRBS23: pay_bit = fb;
            PAT_QRSS:  pay_bit = fb | (zrun_q == ZC_W'(QRSS_MAX_ZEROS));
            PAT_ALT:   pay_bit = alt_q;
            PAT_USER:  pay_bit = user_word[uidx_q];
            default:   pay_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= '1;
            zrun_q <= '0;
            alt_q  <= 1'b0;
            uidx_q <= UIDX_W'(USER_W - 1);
        end else if (adv) begin
            if (uses_lfsr(sel)) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
            if (sel == PAT_QRSS) zrun_q <= pay_bit ? '0 : zrun_q + 1'b1;
            if (sel == PAT_ALT) alt_q <= ~alt_q;
            if (sel == PAT_USER)
                uidx_q <= (uidx_q == '0) ? UIDX_W'(USER_W - 1) : uidx_q - 1'b1;
        end
    end

    // R3: the zero-run counter never passes the forced-one limit
    a_r3_zero_cap: assert property (@(posedge clk) disable iff (rst)
        zrun_q <= ZC_W'(QRSS_MAX_ZEROS));

    // R8: payload state is frozen in cycles with no advance (framing bit slot)
    a_r8_payload_frozen: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(lfsr_q) && $stable(uidx_q) && $stable(alt_q) && $stable(zrun_q));

endmodule

// File: rtl/ds1tp_framer.sv
module ds1tp_framer
    import ds1tp_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int SF_FRAMES  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic framed,
    input  logic esf,
    input  logic finv,
    output logic fslot,
    output logic fbit
);
    localparam int ESF_FRAMES = 2 * SF_FRAMES;
    localparam int BCNT_W     = $clog2(FRAME_BITS);
    localparam int FCNT_W     = $clog2(ESF_FRAMES);

    logic [BCNT_W-1:0] bcnt_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [FCNT_W-1:0] sf_idx;
    logic              sf_bit, esf_bit, twelfth;

    always_comb begin
        sf_idx  = (fcnt_q >= FCNT_W'(SF_FRAMES)) ? fcnt_q - FCNT_W'(SF_FRAMES) : fcnt_q;
        sf_bit  = SF_PATTERN[sf_idx];
        esf_bit = (fcnt_q[1:0] == 2'b11) ? ESF_PATTERN[fcnt_q[FCNT_W-1:2]] : 1'b1;
        twelfth = esf ? (fcnt_q == FCNT_W'(SF_FRAMES - 1))
                      : (sf_idx == FCNT_W'(SF_FRAMES - 1));
        fslot   = framed && (bcnt_q == '0);
        fbit    = (esf ? esf_bit : sf_bit) ^ (finv && twelfth);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
            fcnt_q <= '0;
        end else if (run && framed) begin
            if (bcnt_q == BCNT_W'(FRAME_BITS - 1)) begin
                bcnt_q <= '0;
                fcnt_q <= (fcnt_q == FCNT_W'(ESF_FRAMES - 1)) ? '0 : fcnt_q + 1'b1;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    // R8: the last bit of a frame is followed by a framing bit slot
    a_r8_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && framed && bcnt_q == BCNT_W'(FRAME_BITS - 1)) |=> fslot);

    // R10: the frame counter stays inside one extended superframe
    a_r10_frame_range: assert property (@(posedge clk) disable iff (rst)
        fcnt_q < FCNT_W'(ESF_FRAMES));

    // R7: no framing slot while unframed
    a_r7_unframed_quiet: assert property (@(posedge clk) disable iff (rst)
        (!framed && $past(!framed)) |-> $stable(bcnt_q));

endmodule

// File: rtl/ds1tp_launch.sv
module ds1tp_launch (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_in,
    input  logic rise,
    output logic tx_data,
    output logic tx_valid
);
    logic p_data_q, p_vld_q;
    logic n_data_q, n_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_data_q <= 1'b0;
            p_vld_q  <= 1'b0;
        end else begin
            p_data_q <= run ? bit_in : 1'b0;
            p_vld_q  <= run;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            n_data_q <= 1'b0;
            n_vld_q  <= 1'b0;
        end else begin
            n_data_q <= p_data_q;
            n_vld_q  <= p_vld_q;
        end
    end

    assign tx_data  = rise ? p_data_q : n_data_q;
    assign tx_valid = rise ? p_vld_q  : n_vld_q;

    // R1: reset clears the launch register
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !p_vld_q && !p_data_q);

    // R1: a running generator launches a valid bit on the next edge
    a_r1_launch: assert property (@(posedge clk) disable iff (rst)
        run |=> p_vld_q);

    // R12: the falling-edge copy carries the bit launched on the rising edge
    a_r12_neg_copy: assert property (@(posedge clk) disable iff (rst)
        n_vld_q |-> n_data_q == p_data_q);

endmodule

// File: rtl/ds1_tpat_gen.sv
module ds1_tpat_gen
    import ds1tp_pkg::*;
#(
    parameter int USER_W         = 32,
    parameter int FRAME_BITS     = 193,
    parameter int SF_FRAMES      = 12,
    parameter int QRSS_MAX_ZEROS = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_pattern,
    input  logic              cfg_tx_invert,
    input  logic              cfg_framed,
    input  logic              cfg_esf,
    input  logic              cfg_frame_err,
    input  logic              cfg_rise_edge,
    input  logic [USER_W-1:0] cfg_user_word,
    output logic              tx_data,
    output logic              tx_valid
);
    cfg_t              cfg_q;
    logic [USER_W-1:0] user_q;
    logic              run_q;
    logic              fslot, fbit, pay_bit, adv, out_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            user_q <= '0;
            run_q  <= 1'b0;
        end else begin
            cfg_q  <= '{sel: pat_e'(cfg_pattern), tx_inv: cfg_tx_invert,
                        framed: cfg_framed, esf: cfg_esf, finv: cfg_frame_err,
                        rise: cfg_rise_edge};
            user_q <= cfg_user_word;
            run_q  <= 1'b1;
        end
    end

    assign adv     = run_q && !fslot;
    assign out_bit = (fslot ? fbit : pay_bit) ^ cfg_q.tx_inv;

    ds1tp_payload #(.USER_W(USER_W), .QRSS_MAX_ZEROS(QRSS_MAX_ZEROS)) u_payload (
        .clk(clk), .rst(rst), .sel(cfg_q.sel), .user_word(user_q),
        .adv(adv), .pay_bit(pay_bit)
    );

    ds1tp_framer #(.FRAME_BITS(FRAME_BITS), .SF_FRAMES(SF_FRAMES)) u_framer (
        .clk(clk), .rst(rst), .run(run_q), .framed(cfg_q.framed),
        .esf(cfg_q.esf), .finv(cfg_q.finv), .fslot(fslot), .fbit(fbit)
    );

    ds1tp_launch u_launch (
        .clk(clk), .rst(rst), .run(run_q), .bit_in(out_bit),
        .rise(cfg_q.rise), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    // R1: the generator only runs once reset has been low for an edge
    a_r1_run_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tx_valid || !cfg_q.rise);

endmodule

// File: tb/test_ds1_tpat_gen.sv
module test_ds1_tpat_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_pattern = '0;
    logic        cfg_tx_invert = 1'b0, cfg_framed = 1'b0, cfg_esf = 1'b0;
    logic        cfg_frame_err = 1'b0, cfg_rise_edge = 1'b1;
    logic [31:0] cfg_user_word = '0;
    logic        tx_data, tx_valid;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    ds1_tpat_gen i_ds1_tpat_gen (
        .clk(clk), .rst(rst), .cfg_pattern(cfg_pattern), .cfg_tx_invert(cfg_tx_invert),
        .cfg_framed(cfg_framed), .cfg_esf(cfg_esf), .cfg_frame_err(cfg_frame_err),
        .cfg_rise_edge(cfg_rise_edge), .cfg_user_word(cfg_user_word),
        .tx_data(tx_data), .tx_valid(tx_valid)
    );

    // reference model state
    bit [22:0] m_lfsr;
    int        m_zc, m_uidx, m_b, m_f;
    bit        m_alt;
    int        SFSEQ[12]  = '{1,0,0,0,1,1,0,1,1,1,0,0};
    int        ESFSEQ[6]  = '{0,0,1,0,1,1};

    task automatic chk(input bit got, input bit exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lfsr = '1; m_zc = 0; m_uidx = 31; m_b = 0; m_f = 0; m_alt = 0;
    endtask

    task automatic model_step(output bit b, output string tag);
        bit slot, fb, tw;
        slot = cfg_framed && (m_b == 0);
        if (slot) begin
            if (cfg_esf) begin
                b  = (m_f % 4 == 3) ? ESFSEQ[m_f/4][0] : 1'b1;
                tw = (m_f == 11);
                tag = "R10";
            end else begin
                b  = SFSEQ[m_f % 12][0];
                tw = (m_f % 12 == 11);
                tag = "R9";
            end
            if (cfg_frame_err && tw) begin b = ~b; tag = "R11"; end
            tag = {tag, " R8"};
        end else begin
            case (cfg_pattern)
                3'b000: begin fb = m_lfsr[14] ^ m_lfsr[13]; m_lfsr = {m_lfsr[21:0], fb}; b = fb; tag = "R2"; end
                3'b001: begin fb = m_lfsr[19] ^ m_lfsr[2];  m_lfsr = {m_lfsr[21:0], fb}; b = fb; tag = "R2"; end
                3'b011: begin fb = m_lfsr[22] ^ m_lfsr[17]; m_lfsr = {m_lfsr[21:0], fb}; b = fb; tag = "R2"; end
                3'b010: begin
                    fb = m_lfsr[19] ^ m_lfsr[16]; m_lfsr = {m_lfsr[21:0], fb};
                    b = (m_zc == 13 && !fb) ? 1'b1 : fb;
                    m_zc = b ? 0 : m_zc + 1; tag = "R3";
                end
                3'b100: begin b = m_alt; m_alt = ~m_alt; tag = "R4"; end
                3'b111: begin b = cfg_user_word[m_uidx]; m_uidx = (m_uidx == 0) ? 31 : m_uidx - 1; tag = "R5"; end
                default: begin b = 1'b1; tag = "R4"; end
            endcase
            tag = {tag, cfg_framed ? " R8" : " R7"};
        end
        if (cfg_framed) begin
            if (m_b == 192) begin m_b = 0; m_f = (m_f + 1) % 24; end
            else m_b++;
        end
        if (cfg_tx_invert) begin b = ~b; tag = {tag, " R6"}; end
    endtask

    task automatic run_case(input bit [2:0] sel, input bit inv, input bit frm, input bit esf,
                            input bit finv, input bit rise, input bit [31:0] uw, input int nbits);
        bit exp, prev, e, d, v;
        string tag;
        @(posedge clk); #1;
        rst = 1'b1;
        cfg_pattern = sel; cfg_tx_invert = inv; cfg_framed = frm; cfg_esf = esf;
        cfg_frame_err = finv; cfg_rise_edge = rise; cfg_user_word = uw;
        repeat (2) @(posedge clk);
        #6;
        chk(tx_valid, 1'b0, "R1 valid in reset");
        chk(tx_data, 1'b0, "R1 data in reset");
        @(posedge clk); #1 rst = 1'b0;
        @(posedge clk); #6;
        chk(tx_valid, 1'b0, "R1 valid first edge");
        model_reset();
        prev = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk); #2 e = tx_data;
            #4 d = tx_data; v = tx_valid;
            model_step(exp, tag);
            chk(v, 1'b1, "R1 valid");
            chk(d, exp, tag);
            if (i > 0) chk(e, rise ? exp : prev, "R12 launch edge");
            prev = exp;
        end
    endtask

    initial begin
        int seed_junk;
        bit [2:0] s;
        bit fr, es;
        seed_junk = $urandom(32'h0D51_5EED);
        model_reset();
        // directed: every selector unframed
        for (int p = 0; p < 8; p++)
            run_case(p[2:0], 0, 0, 0, 0, 1, 32'hA5C3_0F81, (p == 2) ? 20000 : 400);
        run_case(3'b111, 0, 1, 0, 0, 1, 32'h8000_0001, 2400);
        run_case(3'b100, 0, 1, 0, 1, 1, 32'h0,         2400);
        run_case(3'b000, 0, 1, 1, 0, 1, 32'h0,         4700);
        run_case(3'b011, 1, 1, 1, 1, 1, 32'h0,         4700);
        run_case(3'b001, 0, 0, 0, 0, 0, 32'h0,         500);
        run_case(3'b101, 1, 1, 0, 1, 0, 32'h0,         2400);
        // constrained random
        for (int k = 0; k < 10; k++) begin
            s  = 3'($urandom);
            fr = 1'($urandom);
            es = 1'($urandom);
            run_case(s, 1'($urandom), fr, es, 1'($urandom), 1'($urandom), $urandom,
                     fr ? (es ? 4700 : 2400) : 800);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule